// File: doc/BRIEF.md
# SPI Flash Command Front-End

This block is the serial command front-end of a NOR flash model. It acts as an SPI slave in clock modes 0 and 3. The SPI pins are brought into the system clock domain by a synchronizer and their edges are detected there. Each period in which chip select is low forms one command frame. A frame is one opcode byte, then an optional 24-bit address, optional dummy bytes, and a data stream that lasts until chip select rises. The read, fast-read, identification, status-read, parallel-mode entry/exit, power-down and wake opcodes are decoded and served in the block.

Array bytes come from a simple memory port: the block drives `mem_addr` and takes `mem_rdata` back in the same cycle. Status bytes come from an external status unit on `stat_in`. Program, erase and status-write commands are not executed here. When the frame ends they are handed to a protection unit on a one-cycle strobe. The strobe carries the opcode, the address that was received and the number of SCK rising edges in the frame. The serial output is modelled as a data bit plus an enable: `spi_so_oe` low means the pin is high-impedance.

Top module: `ffe_top`

## Requirements
- R1: SI is sampled on rising SCK and SO changes only after falling SCK. Identical results are produced in mode 0 (SCK idles low) and mode 3 (SCK idles high).
- R2: Opcode 03h is followed by a 24-bit address, MSB first. From the first falling SCK after the last address bit, array bytes at that address and the following ones stream out MSB first. The address wraps from FFFFFFh to 000000h.
- R3: Opcode 0Bh behaves as 03h, except that one dummy byte is clocked between the address and the first data byte.
- R4: Opcode 9Fh streams the bytes 01h, 20h, 18h, 03h and then the extended byte (parameter `ID_EXT`, default 00h). The five-byte sequence then repeats for as long as the frame lasts.
- R5: Opcode 05h streams the status byte repeatedly. `stat_in` is sampled afresh at the start of every output byte.
- R6: Opcode 55h sets `par_mode` and opcode 45h clears it. Reset clears it, and nothing else changes it. SO stays high-impedance during both frames.
- R7: A frame with opcode B9h sets `pd_active` when chip select rises. While `pd_active` is set, every opcode other than ABh is ignored: SO stays high-impedance, `par_mode` keeps its value and no strobe is issued.
- R8: Opcode ABh is followed by three dummy bytes, after which the signature byte (parameter `ESIG`, default 17h) streams repeatedly. This works whether or not the block is powered down. `pd_active` is cleared when the frame ends.
- R9: A rise of chip select at any bit position aborts the command and returns the bit count to zero. `spi_so_oe` goes low, and the next frame decodes its first byte as an opcode.
- R10: A frame with an unrecognised opcode keeps SO high-impedance for the rest of the frame. It causes no strobe and no change of `par_mode`.
- R11: The request opcodes are 02h and D8h (each followed by an address) and C7h and 01h (without an address). After chip select rises, such a frame produces a one-cycle `wreq_stb` carrying the opcode, the received address (0 if none) and the total SCK rising-edge count of the frame.
- R12: After reset, `spi_so_oe`, `par_mode`, `pd_active` and `wreq_stb` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_si | input | 1 | SPI serial data in |
| spi_so | output | 1 | SPI serial data out |
| spi_so_oe | output | 1 | Output enable for spi_so; low means high-impedance |
| mem_addr | output | 24 | Array byte address |
| mem_rdata | input | 8 | Array byte at mem_addr |
| stat_in | input | 8 | Status byte from the status unit |
| par_mode | output | 1 | Latched parallel-mode flag |
| pd_active | output | 1 | Powered-down state |
| wreq_stb | output | 1 | One-cycle request strobe to the protection unit |
| wreq_opc | output | 8 | Request opcode |
| wreq_addr | output | 24 | Request address |
| wreq_clks | output | 16 | SCK rising edges counted in the request frame |

## Verification
The hardest situation to reach is the powered-down state. In that state a whole family of commands must have no visible effect, and only one opcode may escape it. The stimulus therefore first issues the power-down frame. It then sends a status read, a parallel-mode entry and a program request, and checks at the ports that SO stays disabled, that the mode flag holds and that no strobe appears. Finally it wakes the block with the signature command and confirms that a normal status read works again. The reads are swept over both clock modes, both read opcodes and addresses chosen to cross byte and 24-bit wrap boundaries. The abort case cuts a read off in the middle of a byte.

// File: rtl/ffe_pkg.sv
package ffe_pkg;

    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(BYTE_W);
    localparam int ID_LEN = 5;

    localparam logic [7:0] OPC_READ    = 8'h03;
    localparam logic [7:0] OPC_FREAD   = 8'h0B;
    localparam logic [7:0] OPC_RDID    = 8'h9F;
    localparam logic [7:0] OPC_RDSR    = 8'h05;
    localparam logic [7:0] OPC_PAR_ON  = 8'h55;
    localparam logic [7:0] OPC_PAR_OFF = 8'h45;
    localparam logic [7:0] OPC_PDOWN   = 8'hB9;
    localparam logic [7:0] OPC_WAKE    = 8'hAB;
    localparam logic [7:0] OPC_PROG    = 8'h02;
    localparam logic [7:0] OPC_SERASE  = 8'hD8;
    localparam logic [7:0] OPC_BERASE  = 8'hC7;
    localparam logic [7:0] OPC_WRSR    = 8'h01;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_HOLD,
        ST_IGN
    } ffe_state_e;

    typedef enum logic [1:0] {
        SRC_MEM,
        SRC_ID,
        SRC_STAT,
        SRC_ESIG
    } ffe_src_e;

    function automatic logic [7:0] id_byte(input logic [2:0] idx, input logic [7:0] ext);
        case (idx)
            3'd0:    return 8'h01;
            3'd1:    return 8'h20;
            3'd2:    return 8'h18;
            3'd3:    return 8'h03;
            default: return ext;
        endcase
    endfunction

    function automatic logic is_wr_opc(input logic [7:0] o);
        return (o == OPC_PROG) || (o == OPC_SERASE) || (o == OPC_BERASE) || (o == OPC_WRSR);
    endfunction

    function automatic logic wr_has_addr(input logic [7:0] o);
        return (o == OPC_PROG) || (o == OPC_SERASE);
    endfunction

endpackage

// File: rtl/ffe_sync.sv
module ffe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sck,
    input  logic cs_n,
    input  logic si,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_act,
    output logic cs_end,
    output logic si_s
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sck_p, cs_p, si_p;
    logic              sck_d, cs_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_p <= '0;
            cs_p  <= '1;
            si_p  <= '0;
            sck_d <= 1'b0;
            cs_d  <= 1'b1;
        end else begin
            sck_p <= {sck_p[STAGES-2:0], sck};
            cs_p  <= {cs_p[STAGES-2:0], cs_n};
            si_p  <= {si_p[STAGES-2:0], si};
            sck_d <= sck_p[TOP];
            cs_d  <= cs_p[TOP];
        end
    end

    assign sck_rise = sck_p[TOP] & ~sck_d;
    assign sck_fall = ~sck_p[TOP] & sck_d;
    assign cs_act   = ~cs_p[TOP];
    assign cs_end   = cs_p[TOP] & ~cs_d;
    assign si_s     = si_p[TOP];

endmodule

// File: rtl/ffe_rx.sv
module ffe_rx
    import ffe_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              sck_rise,
    input  logic              si_s,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_val,
    output logic [CNT_W-1:0]  clk_cnt
);
    logic [BIT_W-1:0]  bitc;
    logic [BYTE_W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            bitc     <= '0;
            sr       <= '0;
            byte_vld <= 1'b0;
            byte_val <= '0;
            clk_cnt  <= '0;
        end else begin
            byte_vld <= 1'b0;
            if (sck_rise) begin
                sr   <= {sr[BYTE_W-2:0], si_s};
                bitc <= bitc + 1'b1;
                if (bitc == BIT_W'(BYTE_W - 1)) begin
                    byte_vld <= 1'b1;
                    byte_val <= {sr[BYTE_W-2:0], si_s};
                end
                if (clk_cnt != '1)
                    clk_cnt <= clk_cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/ffe_tx.sv
module ffe_tx
    import ffe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              sck_fall,
    input  logic              tx_on,
    input  logic [BYTE_W-1:0] tx_byte,
    output logic              tx_take,
    output logic              so,
    output logic              so_oe
);
    logic [BIT_W-1:0]  obit;
    logic [BYTE_W-1:0] sr;

    assign tx_take = cs_act && sck_fall && tx_on && (obit == '0);

    always_ff @(posedge clk) begin
        if (rst || !cs_act) begin
            obit  <= '0;
            sr    <= '0;
            so    <= 1'b0;
            so_oe <= 1'b0;
        end else if (sck_fall && tx_on) begin
            if (obit == '0) begin
                so <= tx_byte[BYTE_W-1];
                sr <= {tx_byte[BYTE_W-2:0], 1'b0};
            end else begin
                so <= sr[BYTE_W-1];
                sr <= {sr[BYTE_W-2:0], 1'b0};
            end
            obit  <= obit + 1'b1;
            so_oe <= 1'b1;
        end
    end

endmodule

// File: rtl/ffe_ctrl.sv
module ffe_ctrl
    import ffe_pkg::*;
#(
    parameter int          ADDR_W = 24,
    parameter int          CNT_W  = 16,
    parameter logic [7:0]  ID_EXT = 8'h00,
    parameter logic [7:0]  ESIG   = 8'h17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_act,
    input  logic              cs_end,
    input  logic              byte_vld,
    input  logic [BYTE_W-1:0] byte_val,
    input  logic [CNT_W-1:0]  clk_cnt,
    input  logic              tx_take,
    input  logic [BYTE_W-1:0] mem_rdata,
    input  logic [BYTE_W-1:0] stat_in,
    output logic              tx_on,
    output logic [BYTE_W-1:0] tx_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              par_mode,
    output logic              pd_active,
    output logic              wreq_stb,
    output logic [7:0]        wreq_opc,
    output logic [ADDR_W-1:0] wreq_addr,
    output logic [CNT_W-1:0]  wreq_clks
);
    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int ACNT_W     = $clog2(ADDR_BYTES + 1);
    localparam logic [ACNT_W-1:0] ACNT_LAST = ACNT_W'(ADDR_BYTES - 1);

    ffe_state_e        state;
    ffe_src_e          src;
    logic [7:0]        opc;
    logic              cmd_ok;
    logic              fast;
    logic [ACNT_W-1:0] acnt;
    logic [2:0]        id_idx;
    logic [ADDR_W-1:0] addr;

    assign tx_on    = (state == ST_DATA);
    assign mem_addr = addr;

    always_comb begin
        case (src)
            SRC_MEM:  tx_byte = mem_rdata;
            SRC_ID:   tx_byte = id_byte(id_idx, ID_EXT);
            SRC_STAT: tx_byte = stat_in;
            default:  tx_byte = ESIG;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_OPC;
            src       <= SRC_MEM;
            opc       <= '0;
            cmd_ok    <= 1'b0;
            fast      <= 1'b0;
            acnt      <= '0;
            id_idx    <= '0;
            addr      <= '0;
            par_mode  <= 1'b0;
            pd_active <= 1'b0;
            wreq_stb  <= 1'b0;
            wreq_opc  <= '0;
            wreq_addr <= '0;
            wreq_clks <= '0;
        end else begin
            wreq_stb <= 1'b0;
            if (cs_end && cmd_ok) begin
                if (opc == OPC_PDOWN) pd_active <= 1'b1;
                if (opc == OPC_WAKE)  pd_active <= 1'b0;
                if (is_wr_opc(opc)) begin
                    wreq_stb  <= 1'b1;
                    wreq_opc  <= opc;
                    wreq_addr <= addr;
                    wreq_clks <= clk_cnt;
                end
            end
            if (!cs_act) begin
                state  <= ST_OPC;
                cmd_ok <= 1'b0;
                fast   <= 1'b0;
                acnt   <= '0;
                id_idx <= '0;
                addr   <= '0;
            end else begin
                if (tx_take) begin
                    if (src == SRC_MEM)
                        addr <= addr + 1'b1;
                    else if (src == SRC_ID)
                        id_idx <= (id_idx == 3'(ID_LEN - 1)) ? 3'd0 : id_idx + 3'd1;
                end
                if (byte_vld) begin
                    case (state)
                        ST_OPC: begin
                            opc <= byte_val;
                            if (pd_active && byte_val != OPC_WAKE) begin
                                state <= ST_IGN;
                            end else begin
                                cmd_ok <= 1'b1;
                                case (byte_val)
                                    OPC_READ:    begin src <= SRC_MEM; state <= ST_ADDR; end
                                    OPC_FREAD:   begin src <= SRC_MEM; fast <= 1'b1; state <= ST_ADDR; end
                                    OPC_RDID:    begin src <= SRC_ID; state <= ST_DATA; end
                                    OPC_RDSR:    begin src <= SRC_STAT; state <= ST_DATA; end
                                    OPC_WAKE:    begin src <= SRC_ESIG; state <= ST_ADDR; end
                                    OPC_PAR_ON:  begin par_mode <= 1'b1; state <= ST_HOLD; end
                                    OPC_PAR_OFF: begin par_mode <= 1'b0; state <= ST_HOLD; end
                                    OPC_PDOWN:   state <= ST_HOLD;
                                    default: begin
                                        if (wr_has_addr(byte_val))
                                            state <= ST_ADDR;
                                        else if (is_wr_opc(byte_val))
                                            state <= ST_HOLD;
                                        else begin
                                            cmd_ok <= 1'b0;
                                            state  <= ST_IGN;
                                        end
                                    end
                                endcase
                            end
                        end
                        ST_ADDR: begin
                            addr <= {addr[ADDR_W-BYTE_W-1:0], byte_val};
                            acnt <= acnt + 1'b1;
                            if (acnt == ACNT_LAST) begin
                                if (is_wr_opc(opc))
                                    state <= ST_HOLD;
                                else if (fast)
                                    state <= ST_DUMMY;
                                else
                                    state <= ST_DATA;
                            end
                        end
                        ST_DUMMY: state <= ST_DATA;
                        default:  state <= state;
                    endcase
                end
            end
        end
    end

endmodule

// File: rtl/ffe_top.sv
module ffe_top
    import ffe_pkg::*;
#(
    parameter int         ADDR_W      = 24,
    parameter int         CNT_W       = 16,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ID_EXT      = 8'h00,
    parameter logic [7:0] ESIG        = 8'h17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic [7:0]        stat_in,
    output logic              par_mode,
    output logic              pd_active,
    output logic              wreq_stb,
    output logic [7:0]        wreq_opc,
    output logic [ADDR_W-1:0] wreq_addr,
    output logic [CNT_W-1:0]  wreq_clks
);
    logic              sck_rise, sck_fall, cs_act, cs_end, si_s;
    logic              byte_vld;
    logic [BYTE_W-1:0] byte_val;
    logic [CNT_W-1:0]  clk_cnt;
    logic              tx_on, tx_take;
    logic [BYTE_W-1:0] tx_byte;

    ffe_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst(rst), .sck(spi_sck), .cs_n(spi_cs_n), .si(spi_si),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_act(cs_act),
        .cs_end(cs_end), .si_s(si_s)
    );

    ffe_rx #(.CNT_W(CNT_W)) i_rx (
        .clk(clk), .rst(rst), .cs_act(cs_act), .sck_rise(sck_rise), .si_s(si_s),
        .byte_vld(byte_vld), .byte_val(byte_val), .clk_cnt(clk_cnt)
    );

    ffe_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .ID_EXT(ID_EXT), .ESIG(ESIG)) i_ctrl (
        .clk(clk), .rst(rst), .cs_act(cs_act), .cs_end(cs_end),
        .byte_vld(byte_vld), .byte_val(byte_val), .clk_cnt(clk_cnt),
        .tx_take(tx_take), .mem_rdata(mem_rdata), .stat_in(stat_in),
        .tx_on(tx_on), .tx_byte(tx_byte), .mem_addr(mem_addr),
        .par_mode(par_mode), .pd_active(pd_active),
        .wreq_stb(wreq_stb), .wreq_opc(wreq_opc),
        .wreq_addr(wreq_addr), .wreq_clks(wreq_clks)
    );

    ffe_tx i_tx (
        .clk(clk), .rst(rst), .cs_act(cs_act), .sck_fall(sck_fall),
        .tx_on(tx_on), .tx_byte(tx_byte), .tx_take(tx_take),
        .so(spi_so), .so_oe(spi_so_oe)
    );

endmodule

// File: rtl/ffe_chk.sv
module ffe_chk (
    input logic clk,
    input logic rst,
    input logic cs_act,
    input logic sck_fall,
    input logic byte_vld,
    input logic spi_so,
    input logic spi_so_oe,
    input logic par_mode,
    input logic pd_active,
    input logic wreq_stb
);

    AST_OE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_so_oe) |-> $past(sck_fall)); // R1

    AST_SO_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (cs_act && spi_so_oe && !sck_fall) |=> $stable(spi_so)); // R1

    AST_IDLE_HIZ: assert property (@(posedge clk) disable iff (rst)
        !cs_act |=> !spi_so_oe); // R9

    AST_PAR_ON_BYTE: assert property (@(posedge clk) disable iff (rst)
        !byte_vld |=> $stable(par_mode)); // R6

    AST_PD_NO_REQ: assert property (@(posedge clk) disable iff (rst)
        pd_active |-> !wreq_stb); // R7

    AST_PD_AT_END: assert property (@(posedge clk) disable iff (rst)
        $rose(pd_active) |-> !cs_act); // R7

    AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
        wreq_stb |=> !wreq_stb); // R11

    AST_REQ_OUTSIDE: assert property (@(posedge clk) disable iff (rst)
        wreq_stb |-> !cs_act); // R11

endmodule

bind ffe_top ffe_chk i_chk (
    .clk(clk), .rst(rst), .cs_act(cs_act), .sck_fall(sck_fall),
    .byte_vld(byte_vld), .spi_so(spi_so), .spi_so_oe(spi_so_oe),
    .par_mode(par_mode), .pd_active(pd_active), .wreq_stb(wreq_stb)
);

// File: tb/test_ffe_top.sv
module test_ffe_top;

    localparam int HALF = 8;
    localparam logic [7:0] EXP_EXT  = 8'h00;
    localparam logic [7:0] EXP_ESIG = 8'h17;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sck = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_si = 1'b0;
    logic        spi_so, spi_so_oe;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [7:0]  stat_in = 8'h00;
    logic        par_mode, pd_active, wreq_stb;
    logic [7:0]  wreq_opc;
    logic [23:0] wreq_addr;
    logic [15:0] wreq_clks;

    int vectors = 0;
    int miscompares = 0;
    int stb_count = 0;
    logic [7:0]  cap_opc;
    logic [23:0] cap_addr;
    logic [15:0] cap_clks;
    bit cpol = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    function automatic logic [7:0] memf(input logic [23:0] a);
        return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
    endfunction

    assign mem_rdata = memf(mem_addr);

    ffe_top i_ffe_top (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_si(spi_si),
        .spi_so(spi_so), .spi_so_oe(spi_so_oe), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .stat_in(stat_in), .par_mode(par_mode), .pd_active(pd_active),
        .wreq_stb(wreq_stb), .wreq_opc(wreq_opc), .wreq_addr(wreq_addr), .wreq_clks(wreq_clks)
    );

    always @(negedge clk) begin
        if (wreq_stb) begin
            stb_count <= stb_count + 1;
            cap_opc   <= wreq_opc;
            cap_addr  <= wreq_addr;
            cap_clks  <= wreq_clks;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic frame_begin();
        spi_sck  = cpol;
        tick(2);
        spi_cs_n = 1'b0;
        tick(HALF);
    endtask

    task automatic frame_end();
        if (!cpol) begin
            spi_sck = 1'b0;
            tick(HALF);
        end
        spi_cs_n = 1'b1;
        tick(4 * HALF);
    endtask

    task automatic xbits(input int n, input logic [7:0] t, output logic [7:0] r, output bit oe_any);
        r = '0;
        oe_any = 1'b0;
        for (int i = n - 1; i >= 0; i--) begin
            spi_sck = 1'b0;
            spi_si  = t[i];
            tick(HALF);
            r[i] = spi_so;
            if (spi_so_oe) oe_any = 1'b1;
            spi_sck = 1'b1;
            tick(HALF);
        end
    endtask

    task automatic xbyte(input logic [7:0] t, output logic [7:0] r, output bit oe_any);
        xbits(8, t, r, oe_any);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0]  r;
        bit          oe;
        bit          oe_seen;
        int          base;
        logic [23:0] addrs [4];
        addrs[0] = 24'h000000;
        addrs[1] = 24'h0012FE;
        addrs[2] = 24'h7FFFFF;
        addrs[3] = 24'hFFFFFE;

        tick(10);
        rst = 1'b0;
        tick(4);

        // R12 reset state
        check("R12 so_oe", spi_so_oe, 0);
        check("R12 par_mode", par_mode, 0);
        check("R12 pd_active", pd_active, 0);
        check("R12 wreq_stb", wreq_stb, 0);

        // R1 R2 R3 sweep over clock modes, read opcodes and addresses
        for (int m = 0; m < 2; m++) begin
            cpol = m[0];
            for (int k = 0; k < 4; k++) begin
                for (int f = 0; f < 2; f++) begin
                    frame_begin();
                    xbyte(f ? 8'h0B : 8'h03, r, oe);
                    xbyte(addrs[k][23:16], r, oe);
                    xbyte(addrs[k][15:8], r, oe);
                    xbyte(addrs[k][7:0], r, oe);
                    if (f) begin
                        xbyte(8'h00, r, oe);
                        check("R3 dummy byte keeps SO off", oe, 0);
                    end
                    for (int j = 0; j < 3; j++) begin
                        xbyte(8'h00, r, oe);
                        check(f ? "R3 fast read data" : "R2 read data", r, memf(addrs[k] + 24'(j)));
                        check("R1 so_oe during data", spi_so_oe, 1);
                    end
                    frame_end();
                    check("R9 so_oe after frame", spi_so_oe, 0);
                end
            end
        end

        // R4 identification in both modes, sequence wraps after five bytes
        for (int m = 0; m < 2; m++) begin
            cpol = m[0];
            frame_begin();
            xbyte(8'h9F, r, oe);
            for (int j = 0; j < 7; j++) begin
                logic [7:0] e;
                case (j % 5)
                    0: e = 8'h01;
                    1: e = 8'h20;
                    2: e = 8'h18;
                    3: e = 8'h03;
                    default: e = EXP_EXT;
                endcase
                xbyte(8'h00, r, oe);
                check("R4 id byte", r, e);
            end
            frame_end();
        end

        // R5 status read, re-sampled per byte
        cpol = 1'b0;
        stat_in = 8'h3C;
        frame_begin();
        xbyte(8'h05, r, oe);
        xbyte(8'h00, r, oe);
        check("R5 status byte 1", r, 8'h3C);
        xbyte(8'h00, r, oe);
        check("R5 status byte 2", r, 8'h3C);
        stat_in = 8'hC3;
        xbyte(8'h00, r, oe);
        check("R5 status byte after change", r, 8'hC3);
        frame_end();

        // R6 parallel mode flag
        frame_begin();
        xbyte(8'h55, r, oe);
        xbyte(8'h00, r, oe_seen);
        frame_end();
        check("R6 par_mode set", par_mode, 1);
        check("R6 SO off in entry frame", oe_seen, 0);
        frame_begin();
        xbyte(8'h03, r, oe);
        frame_end();
        check("R6 par_mode persists", par_mode, 1);
        frame_begin();
        xbyte(8'h45, r, oe);
        xbyte(8'h00, r, oe_seen);
        frame_end();
        check("R6 par_mode cleared", par_mode, 0);
        check("R6 SO off in exit frame", oe_seen, 0);

        // R10 unknown opcode
        base = stb_count;
        frame_begin();
        xbyte(8'h3C, r, oe);
        xbyte(8'h55, r, oe_seen);
        xbyte(8'h9F, r, oe);
        oe_seen = oe_seen | oe;
        frame_end();
        check("R10 SO stays off", oe_seen, 0);
        check("R10 no par change", par_mode, 0);
        check("R10 no strobe", stb_count - base, 0);

        // R9 abort mid-byte, then a fresh frame decodes an opcode
        frame_begin();
        xbyte(8'h03, r, oe);
        xbits(4, 8'h0A, r, oe);
        frame_end();
        check("R9 so_oe after abort", spi_so_oe, 0);
        stat_in = 8'h81;
        frame_begin();
        xbyte(8'h05, r, oe);
        xbyte(8'h00, r, oe);
        frame_end();
        check("R9 next frame starts at bit zero", r, 8'h81);

        // R11 request strobes
        base = stb_count;
        frame_begin();
        xbyte(8'h02, r, oe);
        xbyte(8'h12, r, oe);
        xbyte(8'h34, r, oe);
        xbyte(8'h56, r, oe);
        xbyte(8'hAA, r, oe);
        xbyte(8'h55, r, oe);
        frame_end();
        check("R11 program strobe count", stb_count - base, 1);
        check("R11 program opcode", cap_opc, 8'h02);
        check("R11 program address", cap_addr, 24'h123456);
        check("R11 program clocks", cap_clks, 48);
        cpol = 1'b1;
        frame_begin();
        xbyte(8'hD8, r, oe);
        xbyte(8'hAB, r, oe);
        xbyte(8'hCD, r, oe);
        xbyte(8'hEF, r, oe);
        frame_end();
        check("R11 erase strobe count", stb_count - base, 2);
        check("R11 erase opcode", cap_opc, 8'hD8);
        check("R11 erase address", cap_addr, 24'hABCDEF);
        check("R11 erase clocks", cap_clks, 32);
        cpol = 1'b0;
        frame_begin();
        xbyte(8'hC7, r, oe);
        frame_end();
        check("R11 bulk erase opcode", cap_opc, 8'hC7);
        check("R11 bulk erase address", cap_addr, 24'h000000);
        check("R11 bulk erase clocks", cap_clks, 8);
        frame_begin();
        xbyte(8'h01, r, oe);
        xbyte(8'h9C, r, oe);
        xbits(3, 8'h05, r, oe);
        frame_end();
        check("R11 status write opcode", cap_opc, 8'h01);
        check("R11 odd clock count", cap_clks, 19);
        check("R11 strobe total", stb_count - base, 4);

        // R7 power-down: everything but wake is ignored
        frame_begin();
        xbyte(8'hB9, r, oe);
        frame_end();
        check("R7 pd_active set", pd_active, 1);
        stat_in = 8'h42;
        frame_begin();
        xbyte(8'h05, r, oe);
        xbyte(8'h00, r, oe_seen);
        frame_end();
        check("R7 status read ignored", oe_seen, 0);
        frame_begin();
        xbyte(8'h55, r, oe);
        frame_end();
        check("R7 parallel entry ignored", par_mode, 0);
        base = stb_count;
        frame_begin();
        xbyte(8'h02, r, oe);
        xbyte(8'h00, r, oe);
        xbyte(8'h00, r, oe);
        xbyte(8'h10, r, oe);
        frame_end();
        check("R7 program ignored", stb_count - base, 0);
        check("R7 still powered down", pd_active, 1);

        // R8 wake with signature output
        cpol = 1'b1;
        frame_begin();
        xbyte(8'hAB, r, oe);
        xbyte(8'h00, r, oe_seen);
        xbyte(8'h00, r, oe);
        oe_seen = oe_seen | oe;
        xbyte(8'h00, r, oe);
        oe_seen = oe_seen | oe;
        check("R8 SO off during dummy bytes", oe_seen, 0);
        xbyte(8'h00, r, oe);
        check("R8 signature byte 1", r, EXP_ESIG);
        xbyte(8'h00, r, oe);
        check("R8 signature byte 2", r, EXP_ESIG);
        check("R8 still down inside frame", pd_active, 1);
        frame_end();
        check("R8 pd_active cleared", pd_active, 0);
        frame_begin();
        xbyte(8'h05, r, oe);
        xbyte(8'h00, r, oe);
        frame_end();
        check("R8 status works after wake", r, 8'h42);

        finish_run();
    end

endmodule